// File: doc/BRIEF.md
# Edge-Selectable Event Counter With Snapshot

This block counts transitions of an external, asynchronous event input in a wrapping counter, 16 bits wide by default. A small control word decides how counting behaves. One bit selects whether the counter advances on a high-to-low or a low-to-high transition of the input. A self-clearing capture bit copies the whole count into a holding register in one clock edge, so software can read it byte by byte without seeing a torn value. A hold bit stops counting and lets software load a new count.

A low-power polled mode is also provided. In this mode, input transitions count only inside a short sampling window that recurs on a fixed period. The window and period are measured in ticks of a free-running timebase and follow it only while the oscillator enable is high. Turning polled mode on forces low-to-high detection. It also sends a one-cycle clear request to a neighbouring configuration bit outside this block.

Top module: `evt_counter`

## Requirements
- R1: After reset, `count_o`, `snap_o` and `ctrl_o` are all zero.
- R2: With control bit 2 (rise select) at 0, each high-to-low transition of `cnt_pin_i` raises `count_o` by one, three clock edges after the transition is first sampled. A low-to-high transition leaves it unchanged.
- R3: With control bit 2 at 1, each low-to-high transition raises `count_o` by one. A high-to-low transition leaves it unchanged.
- R4: The count wraps from all ones (FFFFh) to zero on the next counted transition.
- R5: A control write with bit 0 (capture) set copies the count present at that clock edge into `snap_o`. `ctrl_o[0]` reads 1 for exactly one cycle after that write and 0 from then on.
- R6: While control bit 1 (hold) is 1, transitions are not counted and `val_we_i` loads `val_wdata_i` into the count. While hold is 0, `val_we_i` is ignored. Counting resumes once hold is cleared.
- R7: A control write with bit 3 (poll) set stores bit 2 as 1, whatever value was written to bit 2. It also drives `cfg_clr_o` high for exactly the one cycle after the write.
- R8: With poll set, a transition counts only while the sampling phase is below `WIN_TICKS`. The phase starts at 0 after reset, advances once per `tick_i` while `osc_en_i` is high, and wraps from `PERIOD_TICKS-1` to 0.
- R9: With poll set and `osc_en_i` low, no transition counts, and `tick_i` does not advance the phase.
- R10: With poll clear, every selected transition counts, whatever the values of `tick_i`, `osc_en_i` and the phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick_i | input | 1 | One-cycle timebase tick |
| osc_en_i | input | 1 | Oscillator enable; high means running |
| cnt_pin_i | input | 1 | Asynchronous event input |
| ctrl_we_i | input | 1 | Control word write strobe |
| ctrl_wdata_i | input | 4 | Control word: bit 3 poll, bit 2 rise select, bit 1 hold, bit 0 capture |
| val_we_i | input | 1 | Count load strobe (effective only while hold is set) |
| val_wdata_i | input | CNT_W | Count load value |
| ctrl_o | output | 4 | Stored control word |
| count_o | output | CNT_W | Live count |
| snap_o | output | CNT_W | Captured count |
| cfg_clr_o | output | 1 | One-cycle clear request to an external configuration bit |

## Verification
The bench builds the block with `PERIOD_TICKS` = 8 and `WIN_TICKS` = 2, keeping the 16-bit counter. With these values, two full laps of the sampling phase take only sixteen tick pulses. The bench freezes the phase between ticks and applies a transition at every phase value, so both window edges and the phase wrap are covered. A loaded value of FFFFh brings the counter wrap within a single transition.

// File: rtl/evt_counter_pkg.sv
package evt_counter_pkg;
  localparam int CTRL_W = 4;

  typedef struct packed {
    logic poll;
    logic rise;
    logic hold;
    logic snap;
  } evt_ctrl_t;
endpackage

// File: rtl/evt_ctrl_reg.sv
module evt_ctrl_reg
  import evt_counter_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output evt_ctrl_t         ctrl_o,
  output logic              snap_req_o,
  output logic              cfg_clr_o
);
  evt_ctrl_t ctrl_q, ctrl_d, wr_word;
  logic      clr_q, clr_d;

  assign wr_word = evt_ctrl_t'(wdata_i);

  always_comb begin
    ctrl_d      = ctrl_q;
    ctrl_d.snap = 1'b0;
    if (we_i) begin
      ctrl_d = wr_word;
      if (wr_word.poll) begin
        ctrl_d.rise = 1'b1;
      end
    end
    clr_d = we_i & wr_word.poll;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      clr_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      clr_q  <= clr_d;
    end
  end

  assign ctrl_o     = ctrl_q;
  assign snap_req_o = we_i & wr_word.snap;
  assign cfg_clr_o  = clr_q;

  p_poll_forces_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.poll |-> ctrl_q.rise);
  p_snap_self_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.snap && !we_i) |=> !ctrl_q.snap);
  p_clr_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_q && !we_i) |=> !clr_q);
endmodule

// File: rtl/evt_sync_edge.sv
module evt_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic rise_sel_i,
  output logic evt_o
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              last_q;
  logic              lvl;

  assign lvl = sync_q[STAGES-1];

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], pin_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= lvl;
    end
  end

  assign evt_o = rise_sel_i ? (lvl & ~last_q) : (~lvl & last_q);

  p_evt_needs_change_r2: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o |=> (last_q != $past(last_q)));
endmodule

// File: rtl/evt_poll_sched.sv
module evt_poll_sched #(
  parameter int PERIOD_TICKS = 4096,
  parameter int WIN_TICKS    = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic osc_en_i,
  output logic win_o
);
  localparam int PH_W = (PERIOD_TICKS > 1) ? $clog2(PERIOD_TICKS) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(PERIOD_TICKS - 1);
  localparam logic [PH_W:0]   WIN_LIM = (PH_W + 1)'(WIN_TICKS);

  logic [PH_W-1:0] phase_q, phase_d;
  logic            adv;

  assign adv = tick_i & osc_en_i;

  always_comb begin
    phase_d = phase_q;
    if (adv) begin
      phase_d = (phase_q == PH_LAST) ? '0 : phase_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_d;
    end
  end

  assign win_o = osc_en_i & ({1'b0, phase_q} < WIN_LIM);

  p_phase_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q <= PH_LAST);
  p_phase_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en_i |=> $stable(phase_q));
endmodule

// File: rtl/evt_counter.sv
module evt_counter
  import evt_counter_pkg::*;
#(
  parameter int CNT_W        = 16,
  parameter int SYNC_STAGES  = 2,
  parameter int PERIOD_TICKS = 4096,
  parameter int WIN_TICKS    = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              osc_en_i,
  input  logic              cnt_pin_i,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  input  logic              val_we_i,
  input  logic [CNT_W-1:0]  val_wdata_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [CNT_W-1:0]  count_o,
  output logic [CNT_W-1:0]  snap_o,
  output logic              cfg_clr_o
);
  logic             rst_meta_q, rst_sync_n;
  evt_ctrl_t        ctrl;
  logic             snap_req, evt, win, accept;
  logic [CNT_W-1:0] cnt_q, cnt_d, snap_q, snap_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  evt_ctrl_reg u_ctrl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .we_i       (ctrl_we_i),
    .wdata_i    (ctrl_wdata_i),
    .ctrl_o     (ctrl),
    .snap_req_o (snap_req),
    .cfg_clr_o  (cfg_clr_o)
  );

  evt_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .pin_i      (cnt_pin_i),
    .rise_sel_i (ctrl.rise),
    .evt_o      (evt)
  );

  evt_poll_sched #(.PERIOD_TICKS(PERIOD_TICKS), .WIN_TICKS(WIN_TICKS)) u_sched (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .tick_i   (tick_i),
    .osc_en_i (osc_en_i),
    .win_o    (win)
  );

  assign accept = evt & ~ctrl.hold & (~ctrl.poll | win);

  always_comb begin
    cnt_d  = cnt_q;
    snap_d = snap_q;
    if (ctrl.hold) begin
      if (val_we_i) begin
        cnt_d = val_wdata_i;
      end
    end else if (accept) begin
      cnt_d = cnt_q + 1'b1;
    end
    if (snap_req) begin
      snap_d = cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cnt_q  <= '0;
      snap_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      snap_q <= snap_d;
    end
  end

  assign ctrl_o  = CTRL_W'(ctrl);
  assign count_o = cnt_q;
  assign snap_o  = snap_q;

  p_step_one_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ctrl.hold |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + CNT_W'(1)));
  p_hold_freeze_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ctrl.hold && !val_we_i) |=> $stable(cnt_q));
  p_osc_off_idle_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ctrl.poll && !osc_en_i && !ctrl.hold) |=> $stable(cnt_q));
  p_snap_capture_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    snap_req |=> (snap_q == $past(cnt_q)));
endmodule

// File: tb/evt_counter_bench.sv
module evt_counter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 16;
  localparam int PER        = 8;
  localparam int WIN        = 2;

  logic             clk = 1'b0;
  logic             rst_n, tick_i, osc_en_i, cnt_pin_i, ctrl_we_i, val_we_i;
  logic [3:0]       ctrl_wdata_i, ctrl_o;
  logic [CNT_W-1:0] val_wdata_i, count_o, snap_o;
  logic             cfg_clr_o;

  int n_chk  = 0;
  int n_fail = 0;
  int exp_cnt;
  bit done   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  evt_counter #(.CNT_W(CNT_W), .SYNC_STAGES(2), .PERIOD_TICKS(PER), .WIN_TICKS(WIN)) u_evt_counter (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .osc_en_i(osc_en_i), .cnt_pin_i(cnt_pin_i),
    .ctrl_we_i(ctrl_we_i), .ctrl_wdata_i(ctrl_wdata_i), .val_we_i(val_we_i),
    .val_wdata_i(val_wdata_i), .ctrl_o(ctrl_o), .count_o(count_o), .snap_o(snap_o),
    .cfg_clr_o(cfg_clr_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_cnt(input string tag);
    chk(count_o == CNT_W'(exp_cnt), tag, int'(count_o), exp_cnt);
  endtask

  task automatic wr_ctrl(input logic [3:0] w);
    @(negedge clk); ctrl_we_i = 1'b1; ctrl_wdata_i = w;
    @(negedge clk); ctrl_we_i = 1'b0;
  endtask

  task automatic wr_val(input logic [CNT_W-1:0] v);
    @(negedge clk); val_we_i = 1'b1; val_wdata_i = v;
    @(negedge clk); val_we_i = 1'b0;
  endtask

  task automatic pin(input logic v);
    @(negedge clk); cnt_pin_i = v;
    repeat (5) @(negedge clk);
  endtask

  task automatic tick_pulse();
    @(negedge clk); tick_i = 1'b1;
    @(negedge clk); tick_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tick_i = 1'b0; osc_en_i = 1'b1; cnt_pin_i = 1'b0;
    ctrl_we_i = 1'b0; ctrl_wdata_i = '0; val_we_i = 1'b0; val_wdata_i = '0;
    exp_cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(count_o == 0, "R1 count", int'(count_o), 0);
    chk(snap_o == 0, "R1 snap", int'(snap_o), 0);
    chk(ctrl_o == 0, "R1 ctrl", int'(ctrl_o), 0);

    // R2 falling-edge mode, several pulses
    for (int i = 0; i < 5; i++) begin
      pin(1'b1); chk_cnt("R2 rise ignored");
      pin(1'b0); exp_cnt++; chk_cnt("R2 fall counted");
    end

    // R3 rising-edge mode
    wr_ctrl(4'b0100);
    for (int i = 0; i < 5; i++) begin
      pin(1'b1); exp_cnt++; chk_cnt("R3 rise counted");
      pin(1'b0); chk_cnt("R3 fall ignored");
    end

    // R6 hold and load
    wr_ctrl(4'b0110);
    pin(1'b1); pin(1'b0); pin(1'b1); chk_cnt("R6 edges ignored in hold");
    wr_val(16'h1234); exp_cnt = 'h1234; chk_cnt("R6 load in hold");
    pin(1'b0);
    wr_ctrl(4'b0100);
    wr_val(16'h5555); chk_cnt("R6 load ignored without hold");
    pin(1'b1); exp_cnt++; chk_cnt("R6 counting resumes");
    pin(1'b0);

    // R5 capture
    wr_ctrl(4'b0101);
    chk(snap_o == CNT_W'(exp_cnt), "R5 snapshot value", int'(snap_o), exp_cnt);
    chk(ctrl_o[0] == 1'b1, "R5 capture bit set", int'(ctrl_o[0]), 1);
    @(negedge clk);
    chk(ctrl_o[0] == 1'b0, "R5 capture bit cleared", int'(ctrl_o[0]), 0);
    pin(1'b1); exp_cnt++; chk_cnt("R5 count after capture");
    chk(snap_o == CNT_W'(exp_cnt - 1), "R5 snapshot held", int'(snap_o), exp_cnt - 1);
    pin(1'b0);

    // R4 wrap
    wr_ctrl(4'b0110);
    wr_val(16'hFFFF);
    wr_ctrl(4'b0100);
    exp_cnt = 'hFFFF; chk_cnt("R4 loaded all ones");
    pin(1'b1); exp_cnt = 0; chk_cnt("R4 wrap to zero");
    pin(1'b0);

    // R7 poll forces rise, clear pulse
    wr_ctrl(4'b1000);
    chk(ctrl_o == 4'b1100, "R7 poll forces rise", int'(ctrl_o), 'hC);
    chk(cfg_clr_o == 1'b1, "R7 clear pulse high", int'(cfg_clr_o), 1);
    @(negedge clk);
    chk(cfg_clr_o == 1'b0, "R7 clear pulse ends", int'(cfg_clr_o), 0);

    // R8 sweep phase over two laps, phase frozen between ticks
    for (int p = 0; p < 2 * PER; p++) begin
      pin(1'b1);
      if ((p % PER) < WIN) exp_cnt++;
      chk_cnt($sformatf("R8 window phase %0d", p % PER));
      pin(1'b0);
      tick_pulse();
    end

    // R9 oscillator off
    osc_en_i = 1'b0;
    pin(1'b1); chk_cnt("R9 no count with osc off");
    tick_pulse();
    pin(1'b0);
    osc_en_i = 1'b1;
    pin(1'b1); exp_cnt++; chk_cnt("R9 phase frozen while osc off");
    pin(1'b0);

    // R10 continuous mode ignores phase and osc
    wr_ctrl(4'b0100);
    for (int k = 0; k < 5; k++) tick_pulse();
    pin(1'b1); exp_cnt++; chk_cnt("R10 counts outside window");
    pin(1'b0);
    osc_en_i = 1'b0;
    pin(1'b1); exp_cnt++; chk_cnt("R10 counts with osc off");
    pin(1'b0);
    osc_en_i = 1'b1;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule